// File: doc/BRIEF.md
# Compressed Activation Stream Router

This block steers input-activation streams inside one cluster group of an accelerator array. Every stream is a compressed sparse pair: an address channel and a data channel, and each channel carries its own payload, valid and ready. The router has four ingress ports: the global buffer, the north neighbour, the south neighbour and the horizontal neighbour. It also has four egress ports: the local PE cluster, north, south and horizontal.

An external controller picks the single active ingress and the single active egress with two 2-bit codes. This covers unicast, vertical, horizontal and broadcast arrangements built across several routers. The router is pure steering logic with no storage. Payload and valid move forward from the chosen ingress to the chosen egress. Ready moves backward from that egress to that ingress. The address and data channels never share a handshake.

Top module: `act_stream_router`

## Requirements
- R1: The ingress code picks the port with the same index: 0 is the global buffer, 1 is north, 2 is south and 3 is horizontal. Port k occupies bits [k*W +: W] of each packed payload bus and bit k of each valid or ready vector.
- R2: The egress code picks the port with the same index: 0 is the PE cluster, 1 is north, 2 is south and 3 is horizontal. It uses the same packing as R1.
- R3: In the same cycle, with no register on the path, the payload and valid of the selected ingress appear on the selected egress. This holds separately for the address channel and the data channel.
- R4: In the same cycle, the ready of the selected egress is returned as the ready of the selected ingress, separately per channel.
- R5: On every ingress other than the selected one, the address ready and the data ready are both 0.
- R6: On every egress other than the selected one, the address valid and the data valid are both 0, and the payload is driven to 0.
- R7: The address channel and the data channel handshake independently. Holding one channel's egress ready low does not stop transfers on the other channel.
- R8: The address width and the data width are parameters, with defaults of 4 and 12 bits.
- R9: Under random valid gaps and random backpressure, the sequence of words accepted at the egress of each channel equals, in order and with nothing added or lost, the sequence accepted at the ingress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_sel | input | 2 | Ingress code (R1) |
| dst_sel | input | 2 | Egress code (R2) |
| in_adr_bits | input | 4*ADR_W | Address payload of the four ingress ports |
| in_adr_valid | input | 4 | Address valid per ingress |
| in_adr_ready | output | 4 | Address ready per ingress |
| in_dat_bits | input | 4*DAT_W | Data payload of the four ingress ports |
| in_dat_valid | input | 4 | Data valid per ingress |
| in_dat_ready | output | 4 | Data ready per ingress |
| out_adr_bits | output | 4*ADR_W | Address payload of the four egress ports |
| out_adr_valid | output | 4 | Address valid per egress |
| out_adr_ready | input | 4 | Address ready per egress |
| out_dat_bits | output | 4*DAT_W | Data payload of the four egress ports |
| out_dat_valid | output | 4 | Data valid per egress |
| out_dat_ready | input | 4 | Data ready per egress |

## Verification
A forward transfer and a backward stall can meet in the same cycle. Valid is moving out on one channel while the other channel's ready is being held low. Also, an unselected port can raise its valid or ready in the same cycle that the selected pair completes a transfer. The sweep applies every ingress and egress code pair against all 16 valid patterns and all 16 ready patterns. It gives the two channels deliberately different patterns and compares every output bit with a value computed from the codes. A clocked stream phase keeps the data sink stalled for a window while addresses flow, and it judges the result by the order and count of the words accepted on both sides.

// File: rtl/car_pkg.sv
package car_pkg;
  localparam int unsigned CAR_PORTS = 4;
  localparam int unsigned CAR_SELW  = $clog2(CAR_PORTS);

  typedef enum logic [CAR_SELW-1:0] {
    SRC_GBUF  = 2'd0,
    SRC_NORTH = 2'd1,
    SRC_SOUTH = 2'd2,
    SRC_HORIZ = 2'd3
  } src_sel_e;

  typedef enum logic [CAR_SELW-1:0] {
    DST_PE    = 2'd0,
    DST_NORTH = 2'd1,
    DST_SOUTH = 2'd2,
    DST_HORIZ = 2'd3
  } dst_sel_e;
endpackage

// File: rtl/car_sel_decode.sv
module car_sel_decode #(
  parameter int unsigned N  = 4,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic [SW-1:0] code,
  output logic [N-1:0]  hot
);
  for (genvar g = 0; g < N; g++) begin : g_hot
    assign hot[g] = (code == SW'(g));
  end
endmodule

// File: rtl/car_chan_steer.sv
module car_chan_steer #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 4
) (
  input  logic [N-1:0]   src_hot,
  input  logic [N-1:0]   dst_hot,
  input  logic [N*W-1:0] in_bits,
  input  logic [N-1:0]   in_valid,
  output logic [N-1:0]   in_ready,
  output logic [N*W-1:0] out_bits,
  output logic [N-1:0]   out_valid,
  input  logic [N-1:0]   out_ready
);
  logic [W-1:0] pick_bits;
  logic         pick_valid;
  logic         pick_ready;

  // AND-OR multiplexers: the forward path follows src, the return path follows dst
  always_comb begin
    pick_bits  = '0;
    pick_valid = 1'b0;
    pick_ready = 1'b0;
    for (int i = 0; i < N; i++) begin
      pick_bits  = pick_bits  | (in_bits[i*W +: W] & {W{src_hot[i]}});
      pick_valid = pick_valid | (in_valid[i] & src_hot[i]);
      pick_ready = pick_ready | (out_ready[i] & dst_hot[i]);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_port
    assign out_valid[g]        = dst_hot[g] & pick_valid;
    assign out_bits[g*W +: W]  = dst_hot[g] ? pick_bits : '0;
    assign in_ready[g]         = src_hot[g] & pick_ready;
  end

  always_comb begin
    assert_one_egress_valid_R6: assert ($onehot0(out_valid));
    assert_one_ingress_ready_R5: assert ($onehot0(in_ready));
    assert_valid_has_source_R3: assert (!(|out_valid) || (|(in_valid & src_hot)));
    assert_ready_has_sink_R4: assert (!(|in_ready) || (|(out_ready & dst_hot)));
  end
endmodule

// File: rtl/act_stream_router.sv
module act_stream_router
  import car_pkg::*;
#(
  parameter int unsigned ADR_W = 4,
  parameter int unsigned DAT_W = 12
) (
  input  logic [CAR_SELW-1:0]        src_sel,
  input  logic [CAR_SELW-1:0]        dst_sel,
  input  logic [CAR_PORTS*ADR_W-1:0] in_adr_bits,
  input  logic [CAR_PORTS-1:0]       in_adr_valid,
  output logic [CAR_PORTS-1:0]       in_adr_ready,
  input  logic [CAR_PORTS*DAT_W-1:0] in_dat_bits,
  input  logic [CAR_PORTS-1:0]       in_dat_valid,
  output logic [CAR_PORTS-1:0]       in_dat_ready,
  output logic [CAR_PORTS*ADR_W-1:0] out_adr_bits,
  output logic [CAR_PORTS-1:0]       out_adr_valid,
  input  logic [CAR_PORTS-1:0]       out_adr_ready,
  output logic [CAR_PORTS*DAT_W-1:0] out_dat_bits,
  output logic [CAR_PORTS-1:0]       out_dat_valid,
  input  logic [CAR_PORTS-1:0]       out_dat_ready
);
  logic [CAR_PORTS-1:0] src_hot;
  logic [CAR_PORTS-1:0] dst_hot;

  // one decode per direction, shared by both channels
  car_sel_decode #(.N(CAR_PORTS)) u_src_dec (.code(src_sel), .hot(src_hot));
  car_sel_decode #(.N(CAR_PORTS)) u_dst_dec (.code(dst_sel), .hot(dst_hot));

  car_chan_steer #(.N(CAR_PORTS), .W(ADR_W)) u_adr (
    .src_hot  (src_hot),
    .dst_hot  (dst_hot),
    .in_bits  (in_adr_bits),
    .in_valid (in_adr_valid),
    .in_ready (in_adr_ready),
    .out_bits (out_adr_bits),
    .out_valid(out_adr_valid),
    .out_ready(out_adr_ready)
  );

  car_chan_steer #(.N(CAR_PORTS), .W(DAT_W)) u_dat (
    .src_hot  (src_hot),
    .dst_hot  (dst_hot),
    .in_bits  (in_dat_bits),
    .in_valid (in_dat_valid),
    .in_ready (in_dat_ready),
    .out_bits (out_dat_bits),
    .out_valid(out_dat_valid),
    .out_ready(out_dat_ready)
  );

  always_comb begin
    assert_adr_egress_tracks_code_R2: assert (!(|out_adr_valid) || out_adr_valid[dst_sel]);
    assert_dat_ingress_tracks_code_R1: assert (!(|in_dat_ready) || in_dat_ready[src_sel]);
    assert_adr_fwd_bits_R3: assert (!out_adr_valid[dst_sel] ||
      (out_adr_bits[dst_sel*ADR_W +: ADR_W] == in_adr_bits[src_sel*ADR_W +: ADR_W]));
  end
endmodule

// File: tb/sim_act_stream_router.sv
module sim_act_stream_router;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 12;
  localparam int NP = 4;
  localparam int NCYC = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]       src_sel, dst_sel;
  logic [NP*AW-1:0] in_adr_bits, out_adr_bits;
  logic [NP*DW-1:0] in_dat_bits, out_dat_bits;
  logic [NP-1:0]    in_adr_valid, in_adr_ready, in_dat_valid, in_dat_ready;
  logic [NP-1:0]    out_adr_valid, out_adr_ready, out_dat_valid, out_dat_ready;

  act_stream_router u0 (
    .src_sel(src_sel), .dst_sel(dst_sel),
    .in_adr_bits(in_adr_bits), .in_adr_valid(in_adr_valid), .in_adr_ready(in_adr_ready),
    .in_dat_bits(in_dat_bits), .in_dat_valid(in_dat_valid), .in_dat_ready(in_dat_ready),
    .out_adr_bits(out_adr_bits), .out_adr_valid(out_adr_valid), .out_adr_ready(out_adr_ready),
    .out_dat_bits(out_dat_bits), .out_dat_valid(out_dat_valid), .out_dat_ready(out_dat_ready)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [AW-1:0] sent_a [NCYC], recv_a [NCYC];
  logic [DW-1:0] sent_d [NCYC], recv_d [NCYC];
  int ns_a, nr_a, ns_d, nr_d;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [NP*AW-1:0] ea_bits;
    logic [NP*DW-1:0] ed_bits;
    logic [NP-1:0] dv, dr;
    logic a_val, d_val;
    logic [AW-1:0] a_word;
    logic [DW-1:0] d_word;
    bit a_fire, d_fire;
    int win_a0, win_d0, mism;

    src_sel = 2'd0; dst_sel = 2'd0;
    in_adr_bits = '0; in_dat_bits = '0;
    in_adr_valid = '0; in_dat_valid = '0;
    out_adr_ready = '0; out_dat_ready = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // idle state: nothing valid, nothing ready (R5, R6)
    chk(out_adr_valid == 0 && out_dat_valid == 0, "R6 idle valid", {out_adr_valid, out_dat_valid}, 0);
    chk(in_adr_ready == 0 && in_dat_ready == 0, "R5 idle ready", {in_adr_ready, in_dat_ready}, 0);
    // default widths (R8)
    chk($bits(u0.out_adr_bits) == NP*4 && $bits(u0.out_dat_bits) == NP*12, "R8 widths",
        $bits(u0.out_dat_bits), NP*12);

    // exhaustive sweep of codes, valid and ready patterns
    for (int s = 0; s < NP; s++) begin
      for (int d = 0; d < NP; d++) begin
        for (int v = 0; v < 16; v++) begin
          for (int r = 0; r < 16; r++) begin
            src_sel = 2'(s); dst_sel = 2'(d);
            in_adr_bits = {$urandom, $urandom};
            in_dat_bits = {$urandom, $urandom};
            in_adr_valid = 4'(v);
            dv = ~{in_adr_valid[0], in_adr_valid[3:1]};
            in_dat_valid = dv;
            out_adr_ready = 4'(r);
            dr = 4'(r) ^ 4'b1010;
            out_dat_ready = dr;
            #1;
            ea_bits = '0; ea_bits[d*AW +: AW] = in_adr_bits[s*AW +: AW];
            ed_bits = '0; ed_bits[d*DW +: DW] = in_dat_bits[s*DW +: DW];
            // R1 R2 R3: selected payload lands in the selected slice, others zero (R6)
            chk(out_adr_bits == ea_bits, "R1/R3 adr bits", out_adr_bits, ea_bits);
            chk(out_dat_bits == ed_bits, "R2/R3 dat bits", out_dat_bits, ed_bits);
            // R3 R6: valid only on the selected egress, per channel (R7 differing patterns)
            chk(out_adr_valid == (in_adr_valid[s] ? 4'(1 << d) : 4'd0), "R3/R6 adr valid",
                out_adr_valid, in_adr_valid[s] ? 4'(1 << d) : 4'd0);
            chk(out_dat_valid == (dv[s] ? 4'(1 << d) : 4'd0), "R3/R6/R7 dat valid",
                out_dat_valid, dv[s] ? 4'(1 << d) : 4'd0);
            // R4 R5: ready only on the selected ingress
            chk(in_adr_ready == (out_adr_ready[d] ? 4'(1 << s) : 4'd0), "R4/R5 adr ready",
                in_adr_ready, out_adr_ready[d] ? 4'(1 << s) : 4'd0);
            chk(in_dat_ready == (dr[d] ? 4'(1 << s) : 4'd0), "R4/R5/R7 dat ready",
                in_dat_ready, dr[d] ? 4'(1 << s) : 4'd0);
          end
        end
      end
    end

    // stream phase: south ingress to horizontal egress, random gaps and backpressure
    src_sel = 2'd2; dst_sel = 2'd3;
    ns_a = 0; nr_a = 0; ns_d = 0; nr_d = 0;
    a_val = 0; d_val = 0; a_word = '0; d_word = '0;
    win_a0 = 0; win_d0 = 0;
    @(negedge clk);
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      a_fire = in_adr_valid[2] && in_adr_ready[2];
      d_fire = in_dat_valid[2] && in_dat_ready[2];
      if (a_fire) begin sent_a[ns_a] = in_adr_bits[2*AW +: AW]; ns_a++; end
      if (d_fire) begin sent_d[ns_d] = in_dat_bits[2*DW +: DW]; ns_d++; end
      if (out_adr_valid[3] && out_adr_ready[3]) begin recv_a[nr_a] = out_adr_bits[3*AW +: AW]; nr_a++; end
      if (out_dat_valid[3] && out_dat_ready[3]) begin recv_d[nr_d] = out_dat_bits[3*DW +: DW]; nr_d++; end
      if (c == 500) begin win_a0 = nr_a; win_d0 = nr_d; end
      @(negedge clk);
      if (a_fire || !a_val) begin
        a_val = ($urandom % 4) != 0;
        if (a_val) a_word = a_word + AW'($urandom % 3 + 1);
      end
      if (d_fire || !d_val) begin
        d_val = ($urandom % 3) != 0;
        if (d_val) d_word = d_word + DW'($urandom % 7 + 1);
      end
      // unselected ports keep toggling with junk
      in_adr_bits = {$urandom, $urandom};
      in_dat_bits = {$urandom, $urandom};
      in_adr_valid = 4'($urandom);
      in_dat_valid = 4'($urandom);
      in_adr_valid[2] = a_val; in_adr_bits[2*AW +: AW] = a_word;
      in_dat_valid[2] = d_val; in_dat_bits[2*DW +: DW] = d_word;
      out_adr_ready = 4'($urandom);
      out_dat_ready = 4'($urandom);
      if (c >= 500 && c < 800) out_dat_ready[3] = 1'b0;
      if (c == 800) begin
        // R7: addresses kept flowing while the data sink stalled
        chk(nr_a - win_a0 > 20, "R7 adr flows under dat stall", nr_a - win_a0, 21);
        chk(nr_d == win_d0, "R7 dat held", nr_d, win_d0);
      end
    end
    chk(ns_a == nr_a && ns_a > 100, "R9 adr count", nr_a, ns_a);
    chk(ns_d == nr_d && ns_d > 100, "R9 dat count", nr_d, ns_d);
    mism = 0;
    for (int k = 0; k < nr_a && k < ns_a; k++) if (recv_a[k] != sent_a[k]) mism++;
    chk(mism == 0, "R9 adr order", mism, 0);
    mism = 0;
    for (int k = 0; k < nr_d && k < ns_d; k++) if (recv_d[k] != sent_d[k]) mism++;
    chk(mism == 0, "R9 dat order", mism, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule